// File: doc/BRIEF.md
# Row-Aware Memory Request Reorder Queue

This block sits between request sources and a DRAM-style controller. It stores up to `DEPTH` pending read or write requests, each with an address, a tag and a write flag, and decides which one goes out next. Two address fields drive the decision: a row index and a burst index, each a parameterised slice of the address.

The queue remembers the row and burst of the request it issued last. On the next issue it first promotes a queued request that hits both that row and that burst, so that it can be merged into the same transfer. If there is none, it promotes a request in the same open row. If neither exists, it falls back to arrival order. Among equal candidates the oldest wins. Each entry also counts how many times a younger entry overtook it. Once that count reaches `AGE_LIMIT`, the entry is forced out next, which bounds how long any request can wait.

Requests enter through a valid/ready port and leave through a valid/ready port. Both ports may fire in the same cycle. The entries behind the issued slot move up one place, so slot order always equals arrival order.

Top module: `rq_reorder`

## Requirements
- R1: After a synchronous reset the queue is empty: `occupancy` reads 0, `deq_valid` is low and `enq_ready` is high. The remembered last-issued row and burst are cleared and invalid, so the first issue after reset is the oldest entry, even if its row field is 0.
- R2: While `occupancy` is 0, `deq_valid` stays low and nothing issues, even when `deq_ready` is high.
- R3: After an issue, if a queued entry has the same row (address bits [15:10]) and the same burst (address bits [9:6]) as the issued request, such an entry issues next, ahead of all other non-aged entries.
- R4: If no queued entry matches both row and burst, but one matches the row of the last issued request, a row-matching entry issues next, ahead of older unrelated entries.
- R5: If no queued entry matches the last issued row, the oldest entry issues. The most recently accepted entry therefore does not issue next unless it is the only entry.
- R6: When several entries share the winning priority level, the oldest of them issues first.
- R7: An entry that has been overtaken `AGE_LIMIT` (16) times issues next, regardless of row or burst matches. If several entries qualify, the oldest goes first.
- R8: An enqueue and a dequeue may happen in the same cycle. `occupancy` then follows old count + accepted enqueues − issued dequeues.
- R9: `enq_ready` is low exactly when `occupancy` equals `DEPTH` (8). A request offered while the queue is full is dropped and never issues.
- R10: Every issued tag, address and write flag equals that of a previously accepted request that has not yet issued. No request is lost or issued twice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | A new request is offered |
| enq_ready | output | 1 | The queue can accept a request |
| enq_addr | input | AW (16) | Request address |
| enq_tag | input | TAG_W (8) | Request identifier |
| enq_write | input | 1 | 1 = write, 0 = read |
| deq_valid | output | 1 | A request is available to issue |
| deq_ready | input | 1 | The controller takes the presented request |
| deq_addr | output | AW (16) | Address of the presented request |
| deq_tag | output | TAG_W (8) | Tag of the presented request |
| deq_write | output | 1 | Write flag of the presented request |
| occupancy | output | $clog2(DEPTH+1) (4) | Number of queued requests |

## Verification
The bench builds the queue with its default parameters: eight slots, a 6-bit row at bit 10, a 4-bit burst at bit 6, 8-bit tags and an ageing limit of 16. With eight slots the full-queue case is reached in a few cycles. The limit of 16 lets one directed sequence overtake a single old entry exactly sixteen times and watch it forced out on the next issue. The random phase draws rows and bursts from a small set of values, so burst merges, row promotions and occasional ageing all occur in the same traffic.

// File: rtl/rq_pkg.sv
package rq_pkg;

   // which rule chose the entry presented at the dequeue port
   typedef enum logic [1:0] {
      PICK_AGED  = 2'd0,
      PICK_BURST = 2'd1,
      PICK_ROW   = 2'd2,
      PICK_ORDER = 2'd3
   } pick_e;

   // width of a per-entry overtake counter for a given limit
   function automatic int age_width(input int limit);
      return (limit > 0) ? $clog2(limit + 1) : 1;
   endfunction

endpackage

// File: rtl/rq_store.sv
module rq_store #(
   parameter int DEPTH     = 8,
   parameter int AW        = 16,
   parameter int TAG_W     = 8,
   parameter int AGE_LIMIT = 16,
   parameter int AGE_W     = 5,
   parameter int IDX_W     = 3,
   parameter int CNT_W     = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             enq_fire,
   input  logic [AW-1:0]    enq_addr,
   input  logic [TAG_W-1:0] enq_tag,
   input  logic             enq_write,
   input  logic             deq_fire,
   input  logic [IDX_W-1:0] deq_sel,
   output logic [AW-1:0]    slot_addr  [DEPTH],
   output logic [TAG_W-1:0] slot_tag   [DEPTH],
   output logic             slot_write [DEPTH],
   output logic [AGE_W-1:0] slot_age   [DEPTH],
   output logic [CNT_W-1:0] count
);

   localparam logic [AGE_W-1:0] AGE_CAP = AGE_W'(AGE_LIMIT);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] wr_idx;

   // new request lands just behind the last entry that survives this cycle
   assign wr_idx = cnt_q - CNT_W'(deq_fire);
   assign count  = cnt_q;

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_q + CNT_W'(enq_fire) - CNT_W'(deq_fire);
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [AW-1:0]    nb_addr;
      logic [TAG_W-1:0] nb_tag;
      logic             nb_write;
      logic [AGE_W-1:0] nb_age;
      logic             load_new;
      logic             shift_up;
      logic             bypassed;

      if (g < DEPTH - 1) begin : g_nb
         assign nb_addr  = slot_addr[g+1];
         assign nb_tag   = slot_tag[g+1];
         assign nb_write = slot_write[g+1];
         assign nb_age   = slot_age[g+1];
      end else begin : g_tail
         assign nb_addr  = '0;
         assign nb_tag   = '0;
         assign nb_write = 1'b0;
         assign nb_age   = '0;
      end

      assign load_new = enq_fire && (wr_idx == CNT_W'(g));
      assign shift_up = deq_fire && (IDX_W'(g) >= deq_sel);
      assign bypassed = deq_fire && (IDX_W'(g) < deq_sel) && (CNT_W'(g) < cnt_q);

      always_ff @(posedge clk) begin
         if (rst) begin
            slot_addr[g]  <= '0;
            slot_tag[g]   <= '0;
            slot_write[g] <= 1'b0;
            slot_age[g]   <= '0;
         end else if (load_new) begin
            slot_addr[g]  <= enq_addr;
            slot_tag[g]   <= enq_tag;
            slot_write[g] <= enq_write;
            slot_age[g]   <= '0;
         end else if (shift_up) begin
            slot_addr[g]  <= nb_addr;
            slot_tag[g]   <= nb_tag;
            slot_write[g] <= nb_write;
            slot_age[g]   <= nb_age;
         end else if (bypassed && (slot_age[g] != AGE_CAP)) begin
            slot_age[g]   <= slot_age[g] + AGE_W'(1);
         end
      end
   end

   AST_RESET_EMPTY: assert property (@(posedge clk) rst |=> (cnt_q == '0)); // R1
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
      deq_fire |-> (cnt_q != '0)); // R2
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      enq_fire |-> (cnt_q < CNT_W'(DEPTH) || deq_fire)); // R9
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
      (enq_fire != deq_fire) |=> (cnt_q != $past(cnt_q))); // R8
   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (enq_fire == deq_fire) |=> (cnt_q == $past(cnt_q))); // R8

endmodule

// File: rtl/rq_match.sv
module rq_match #(
   parameter int DEPTH     = 8,
   parameter int AW        = 16,
   parameter int ROW_LSB   = 10,
   parameter int ROW_W     = 6,
   parameter int BURST_LSB = 6,
   parameter int BURST_W   = 4,
   parameter int AGE_LIMIT = 16,
   parameter int AGE_W     = 5,
   parameter int CNT_W     = 4
) (
   input  logic               ref_valid,
   input  logic [ROW_W-1:0]   ref_row,
   input  logic [BURST_W-1:0] ref_burst,
   input  logic [AW-1:0]      slot_addr [DEPTH],
   input  logic [AGE_W-1:0]   slot_age  [DEPTH],
   input  logic [CNT_W-1:0]   count,
   output logic [DEPTH-1:0]   row_hit,
   output logic [DEPTH-1:0]   burst_hit,
   output logic [DEPTH-1:0]   aged
);

   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      logic live;
      logic same_row;
      logic same_burst;

      assign live       = CNT_W'(g) < count;
      assign same_row   = slot_addr[g][ROW_LSB +: ROW_W] == ref_row;
      assign same_burst = slot_addr[g][BURST_LSB +: BURST_W] == ref_burst;

      assign row_hit[g]   = live && ref_valid && same_row;
      assign burst_hit[g] = live && ref_valid && same_row && same_burst;

      if (AGE_LIMIT > 0) begin : g_age
         assign aged[g] = live && (slot_age[g] >= AGE_W'(AGE_LIMIT));
      end else begin : g_noage
         logic unused_age;
         assign unused_age = ^slot_age[g];
         assign aged[g]    = 1'b0;
      end
   end

endmodule

// File: rtl/rq_pick.sv
module rq_pick
   import rq_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int IDX_W = 3
) (
   input  logic [DEPTH-1:0] aged,
   input  logic [DEPTH-1:0] burst_hit,
   input  logic [DEPTH-1:0] row_hit,
   output logic [IDX_W-1:0] sel,
   output pick_e            kind
);

   // lowest set bit = oldest candidate, since slot order is arrival order
   function automatic logic [IDX_W-1:0] oldest(input logic [DEPTH-1:0] vec);
      logic [IDX_W-1:0] idx;
      idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
      return idx;
   endfunction

   always_comb begin
      if (|aged) begin
         sel  = oldest(aged);
         kind = PICK_AGED;
      end else if (|burst_hit) begin
         sel  = oldest(burst_hit);
         kind = PICK_BURST;
      end else if (|row_hit) begin
         sel  = oldest(row_hit);
         kind = PICK_ROW;
      end else begin
         sel  = '0;
         kind = PICK_ORDER;
      end
   end

endmodule

// File: rtl/rq_reorder.sv
module rq_reorder
   import rq_pkg::*;
#(
   parameter int DEPTH     = 8,
   parameter int AW        = 16,
   parameter int TAG_W     = 8,
   parameter int ROW_LSB   = 10,
   parameter int ROW_W     = 6,
   parameter int BURST_LSB = 6,
   parameter int BURST_W   = 4,
   parameter int AGE_LIMIT = 16,
   localparam int IDX_W    = $clog2(DEPTH),
   localparam int CNT_W    = $clog2(DEPTH + 1),
   localparam int AGE_W    = rq_pkg::age_width(AGE_LIMIT)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             enq_valid,
   output logic             enq_ready,
   input  logic [AW-1:0]    enq_addr,
   input  logic [TAG_W-1:0] enq_tag,
   input  logic             enq_write,
   output logic             deq_valid,
   input  logic             deq_ready,
   output logic [AW-1:0]    deq_addr,
   output logic [TAG_W-1:0] deq_tag,
   output logic             deq_write,
   output logic [CNT_W-1:0] occupancy
);

   // elaboration-time parameter checks
   if (DEPTH < 2) begin : g_bad_depth
      $error("rq_reorder: DEPTH must be at least 2");
   end
   if (ROW_LSB + ROW_W > AW) begin : g_bad_row
      $error("rq_reorder: row field exceeds address width");
   end
   if (BURST_LSB + BURST_W > AW) begin : g_bad_burst
      $error("rq_reorder: burst field exceeds address width");
   end
   if (AGE_LIMIT < 0) begin : g_bad_age
      $error("rq_reorder: AGE_LIMIT must not be negative");
   end

   logic [AW-1:0]      slot_addr  [DEPTH];
   logic [TAG_W-1:0]   slot_tag   [DEPTH];
   logic               slot_write [DEPTH];
   logic [AGE_W-1:0]   slot_age   [DEPTH];
   logic [CNT_W-1:0]   count;
   logic [DEPTH-1:0]   row_hit, burst_hit, aged;
   logic [IDX_W-1:0]   sel;
   pick_e              kind;
   logic               enq_fire, deq_fire;
   logic               ref_valid;
   logic [ROW_W-1:0]   ref_row;
   logic [BURST_W-1:0] ref_burst;

   assign enq_ready = count != CNT_W'(DEPTH);
   assign deq_valid = count != '0;
   assign enq_fire  = enq_valid && enq_ready;
   assign deq_fire  = deq_valid && deq_ready;
   assign occupancy = count;

   assign deq_addr  = slot_addr[sel];
   assign deq_tag   = slot_tag[sel];
   assign deq_write = slot_write[sel];

   // row and burst of the request that issued last
   always_ff @(posedge clk) begin
      if (rst) begin
         ref_valid <= 1'b0;
         ref_row   <= '0;
         ref_burst <= '0;
      end else if (deq_fire) begin
         ref_valid <= 1'b1;
         ref_row   <= deq_addr[ROW_LSB +: ROW_W];
         ref_burst <= deq_addr[BURST_LSB +: BURST_W];
      end
   end

   rq_store #(
      .DEPTH(DEPTH), .AW(AW), .TAG_W(TAG_W), .AGE_LIMIT(AGE_LIMIT),
      .AGE_W(AGE_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
   ) u_store (
      .clk        (clk),
      .rst        (rst),
      .enq_fire   (enq_fire),
      .enq_addr   (enq_addr),
      .enq_tag    (enq_tag),
      .enq_write  (enq_write),
      .deq_fire   (deq_fire),
      .deq_sel    (sel),
      .slot_addr  (slot_addr),
      .slot_tag   (slot_tag),
      .slot_write (slot_write),
      .slot_age   (slot_age),
      .count      (count)
   );

   rq_match #(
      .DEPTH(DEPTH), .AW(AW), .ROW_LSB(ROW_LSB), .ROW_W(ROW_W),
      .BURST_LSB(BURST_LSB), .BURST_W(BURST_W), .AGE_LIMIT(AGE_LIMIT),
      .AGE_W(AGE_W), .CNT_W(CNT_W)
   ) u_match (
      .ref_valid (ref_valid),
      .ref_row   (ref_row),
      .ref_burst (ref_burst),
      .slot_addr (slot_addr),
      .slot_age  (slot_age),
      .count     (count),
      .row_hit   (row_hit),
      .burst_hit (burst_hit),
      .aged      (aged)
   );

   rq_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
      .aged      (aged),
      .burst_hit (burst_hit),
      .row_hit   (row_hit),
      .sel       (sel),
      .kind      (kind)
   );

   logic [DEPTH-1:0] older_than_sel;
   assign older_than_sel = (DEPTH'(1) << sel) - DEPTH'(1);

   AST_AGED_OUT: assert property (@(posedge clk) disable iff (rst)
      (deq_valid && |aged) |-> (aged[sel] && kind == PICK_AGED)); // R7
   AST_BURST_FIRST: assert property (@(posedge clk) disable iff (rst)
      (deq_valid && !(|aged) && |burst_hit) |-> burst_hit[sel]); // R3
   AST_ROW_NEXT: assert property (@(posedge clk) disable iff (rst)
      (deq_valid && !(|aged) && !(|burst_hit) && |row_hit) |-> row_hit[sel]); // R4
   AST_OLDEST_WINS: assert property (@(posedge clk) disable iff (rst)
      (deq_valid && !(|aged) && |burst_hit) |-> ((burst_hit & older_than_sel) == '0)); // R6
   AST_YOUNGEST_HELD: assert property (@(posedge clk) disable iff (rst)
      (deq_valid && count > CNT_W'(1) && !(|aged) && !(|row_hit))
         |-> (CNT_W'(sel) != count - CNT_W'(1))); // R5
   AST_SEL_LIVE: assert property (@(posedge clk) disable iff (rst)
      deq_valid |-> (CNT_W'(sel) < count)); // R10
   AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
      (count == CNT_W'(DEPTH) && !deq_fire) |=> (count == CNT_W'(DEPTH))); // R9
   AST_FIRST_IS_OLDEST: assert property (@(posedge clk)
      rst |=> !ref_valid); // R1

endmodule

// File: tb/sim_rq_reorder.sv
module sim_rq_reorder;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 8;
   localparam int AGE_LIMIT  = 16;
   localparam int WATCHDOG   = 200000;

   typedef struct {
      logic [15:0] addr;
      logic [7:0]  tag;
      bit          wr;
      int          age;
   } item_t;

   logic       clk = 1'b0;
   logic       rst;
   logic       enq_valid, enq_ready, enq_write;
   logic [15:0] enq_addr;
   logic [7:0]  enq_tag;
   logic       deq_valid, deq_ready, deq_write;
   logic [15:0] deq_addr;
   logic [7:0]  deq_tag;
   logic [3:0]  occupancy;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   item_t     sb_q[$];
   bit        ref_v;
   bit [5:0]  ref_row;
   bit [3:0]  ref_burst;

   always #(CLK_PERIOD / 2) clk = ~clk;

   rq_reorder u0 (
      .clk(clk), .rst(rst),
      .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_addr(enq_addr),
      .enq_tag(enq_tag), .enq_write(enq_write),
      .deq_valid(deq_valid), .deq_ready(deq_ready), .deq_addr(deq_addr),
      .deq_tag(deq_tag), .deq_write(deq_write), .occupancy(occupancy)
   );

   function automatic logic [15:0] mk(input int row, input int burst, input int low);
      return {6'(row), 4'(burst), 6'(low)};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // requirement-level choice of the next entry, computed from the model
   function automatic int pick_idx(output string req);
      for (int i = 0; i < sb_q.size(); i++)
         if (sb_q[i].age >= AGE_LIMIT) begin req = "R7"; return i; end
      if (ref_v) begin
         for (int i = 0; i < sb_q.size(); i++)
            if (sb_q[i].addr[15:10] == ref_row && sb_q[i].addr[9:6] == ref_burst) begin
               req = "R3"; return i;
            end
         for (int i = 0; i < sb_q.size(); i++)
            if (sb_q[i].addr[15:10] == ref_row) begin req = "R4"; return i; end
      end
      req = "R5";
      return 0;
   endfunction

   // driver and monitor for one clock: drives at the falling edge, compares after settling
   task automatic cycle(input bit ev, input logic [15:0] a, input logic [7:0] t,
                        input bit w, input bit dr, output bit got, output logic [7:0] gtag);
      string req;
      int    idx;
      bit    full;
      @(negedge clk);
      enq_valid = ev; enq_addr = a; enq_tag = t; enq_write = w; deq_ready = dr;
      #1;
      full = sb_q.size() >= DEPTH;
      chk(enq_ready === !full, "R9", "enq_ready", enq_ready, !full);
      chk(occupancy == sb_q.size(), "R8", "occupancy", occupancy, sb_q.size());
      chk(deq_valid === (sb_q.size() != 0), "R2", "deq_valid", deq_valid, sb_q.size() != 0);
      got = 0; gtag = '0;
      if (dr && sb_q.size() != 0) begin
         idx = pick_idx(req);
         chk(deq_tag == sb_q[idx].tag, req, "issued tag", deq_tag, sb_q[idx].tag);
         chk(deq_addr == sb_q[idx].addr && deq_write == sb_q[idx].wr, "R10",
             "issued addr/write", {deq_write, deq_addr}, {sb_q[idx].wr, sb_q[idx].addr});
         got = 1; gtag = deq_tag;
         for (int i = 0; i < idx; i++)
            if (sb_q[i].age < AGE_LIMIT) sb_q[i].age++;
         ref_v = 1; ref_row = sb_q[idx].addr[15:10]; ref_burst = sb_q[idx].addr[9:6];
         sb_q.delete(idx);
      end
      if (ev && !full) sb_q.push_back('{addr: a, tag: t, wr: w, age: 0});
   endtask

   task automatic push(input logic [15:0] a, input logic [7:0] t, input bit w);
      bit g; logic [7:0] gt;
      cycle(1, a, t, w, 0, g, gt);
   endtask

   task automatic pop_expect(input logic [7:0] exp, input string req);
      bit g; logic [7:0] gt;
      cycle(0, '0, '0, 0, 1, g, gt);
      chk(g && gt == exp, req, "directed issue order", gt, exp);
   endtask

   task automatic drain();
      bit g; logic [7:0] gt;
      while (sb_q.size() != 0) cycle(0, '0, '0, 0, 1, g, gt);
      cycle(0, '0, '0, 0, 0, g, gt);
   endtask

   initial begin
      bit g; logic [7:0] gt;
      bit seen_drop;
      int n_out;
      logic [7:0] rtag;
      enq_valid = 0; enq_addr = '0; enq_tag = '0; enq_write = 0; deq_ready = 0;
      rst = 1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 0;
      ref_v = 0; ref_row = '0; ref_burst = '0;

      // R1 reset state
      #1;
      chk(occupancy == 0 && !deq_valid && enq_ready, "R1", "reset state",
          {occupancy, deq_valid, enq_ready}, 6'b000001);
      // R2 nothing issues from an empty queue
      cycle(0, '0, '0, 0, 1, g, gt);
      chk(!g, "R2", "issue while empty", g, 0);

      // R1 cleared reference: row-0 entry is not promoted over the oldest
      push(mk(3, 0, 1), 8'h11, 0);
      push(mk(0, 0, 0), 8'h12, 1);
      pop_expect(8'h11, "R1");
      pop_expect(8'h12, "R5");

      // R3 burst merge, R4 row promotion, R5 fallback to arrival order
      push(mk(2, 1, 0), 8'h21, 0);
      push(mk(4, 0, 0), 8'h22, 1);
      push(mk(2, 3, 0), 8'h23, 0);
      push(mk(2, 1, 5), 8'h24, 1);
      pop_expect(8'h21, "R5");
      pop_expect(8'h24, "R3");
      pop_expect(8'h23, "R4");
      pop_expect(8'h22, "R5");

      // R6 equal candidates keep arrival order
      push(mk(5, 2, 0), 8'h31, 0);
      push(mk(6, 0, 0), 8'h32, 0);
      push(mk(5, 2, 1), 8'h33, 1);
      push(mk(5, 2, 2), 8'h34, 0);
      push(mk(5, 7, 0), 8'h35, 1);
      pop_expect(8'h31, "R5");
      pop_expect(8'h33, "R6");
      pop_expect(8'h34, "R6");
      pop_expect(8'h35, "R4");
      pop_expect(8'h32, "R5");

      // R5 youngest held back until it is alone
      push(mk(7, 0, 0), 8'h41, 0);
      push(mk(8, 0, 0), 8'h42, 0);
      push(mk(9, 0, 0), 8'h43, 0);
      pop_expect(8'h41, "R5");
      pop_expect(8'h42, "R5");
      pop_expect(8'h43, "R5");

      // R8 simultaneous enqueue and dequeue
      push(mk(10, 0, 0), 8'h51, 0);
      push(mk(11, 0, 0), 8'h52, 0);
      cycle(1, mk(12, 0, 0), 8'h53, 1, 1, g, gt);
      chk(g && gt == 8'h51, "R8", "issue during enqueue", gt, 8'h51);
      cycle(0, '0, '0, 0, 0, g, gt);
      chk(occupancy == 2, "R8", "occupancy after enq+deq", occupancy, 2);
      drain();

      // R9 full queue drops an offered request
      for (int i = 0; i < DEPTH; i++) push(mk(20 + i, 0, 0), 8'h60 + 8'(i), 0);
      push(mk(40, 0, 0), 8'hEE, 1);
      cycle(0, '0, '0, 0, 0, g, gt);
      chk(occupancy == DEPTH, "R9", "occupancy after offer while full", occupancy, DEPTH);
      seen_drop = 0;
      while (sb_q.size() != 0) begin
         cycle(0, '0, '0, 0, 1, g, gt);
         if (g && gt == 8'hEE) seen_drop = 1;
      end
      chk(!seen_drop, "R9", "dropped request issued", seen_drop, 0);

      // R7 an entry overtaken AGE_LIMIT times is forced out next
      push(mk(1, 0, 0), 8'h70, 0);
      push(mk(9, 5, 0), 8'h7F, 1);
      for (int i = 0; i < 5; i++) push(mk(1, i % 3, i), 8'h80 + 8'(i), 0);
      n_out = 0;
      for (int i = 0; i < 18; i++) begin
         cycle(1, mk(1, i % 4, 9), 8'h90 + 8'(i), 0, 1, g, gt);
         if (g) n_out++;
         if (n_out == 17) chk(gt != 8'h7F, "R7", "aged entry issued early", gt, 0);
         if (n_out == 18) chk(gt == 8'h7F, "R7", "aged entry after 16 bypasses", gt, 8'h7F);
      end
      drain();

      // mixed traffic on a few rows and bursts, checked against the model
      rtag = 8'hA0;
      for (int i = 0; i < 1500; i++) begin
         bit ev, dr;
         ev = ($urandom % 4) != 0;
         dr = ($urandom % 3) != 0;
         cycle(ev, mk($urandom % 4, $urandom % 2, $urandom % 64), rtag,
               1'($urandom % 2), dr, g, gt);
         if (ev && enq_ready) rtag++;
      end
      drain();
      chk(occupancy == 0 && !deq_valid, "R10", "empty after drain",
          {occupancy, deq_valid}, 0);

      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      if (!done) begin
         done = 1;
         n_checks++;
         n_fail++;
         $display("FAIL R10 watchdog: actual %0d expected %0d", 1, 0);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule